// File: doc/BRIEF.md
# ATA Task File Register Window

This block is the bus-facing register window for up to four ATA-style disk channels. Each bus access carries a dword address, a write flag, write data and four byte enables. From these the block picks either one task file register of one channel or that channel's data port. The byte enable pattern matters as much as the address. On the first dword of a channel, one byte enable on its own selects one task file register. The patterns for 8, 16 and 32 bits from lane 0 select the data port instead. Two locations return a different register on read than the one they load on write: features/error and command/status.

The writable task file registers are stored here. Error and status come live from device-side inputs. A command write produces a one-cycle strobe toward the device, carrying the command byte and the channel's current features value. Data port traffic is streamed. Writes leave on a valid/ready output stream and reads pop from a valid/ready input stream. Both streams are tagged with the channel number. The bus is held with `bus_stall` until the handshake completes. The bus master must keep the whole request steady while it is stalled. The output stream's `dout_valid` follows the held request, so it stays up until `dout_ready` is seen. A register access never stalls. Every accepted read returns its data exactly one cycle later.

Top module: `ata_tf_window`

## Requirements
- R1: After reset every stored task file register reads zero, and `rd_valid` and `cmd_strobe` stay low while reset is applied.
- R2: Channel c decodes at byte address 0x80 + 0x40*(c mod 2) + 0x200*(c div 2) for its first dword and that address plus 4 for its second. With four channels the first dwords are at 0x80, 0xC0, 0x280 and 0x2C0. `bus_dw_addr` is the byte address divided by 4.
- R3: In the first dword, a lone byte enable selects one register. Enable 4'b1000 is the starting sector byte in bits 31:24, 4'b0100 is the sector count in 23:16, and 4'b0010 is the features (write) / error (read) lane in 15:8.
- R4: In the second dword, a lone byte enable selects one register. Enable 4'b1000 is command/status in 31:24, 4'b0100 is device/head in 23:16, 4'b0010 is cylinder high in 15:8 and 4'b0001 is cylinder low in 7:0.
- R5: A read of the features/error lane returns the channel's `dev_err` byte, and a read of the command/status lane returns its `dev_stat` byte. Writes to those lanes never alter what they read.
- R6: A command write raises bit c of `cmd_strobe` for exactly one cycle, the cycle after the write is accepted. At most one bit is ever high. `cmd_code` carries the written byte and `cmd_feat` the channel's features value at that time.
- R7: Channels 0 and 1 store and return bit 4 of device/head. On channels 2 and 3 that bit ignores writes and always reads 0.
- R8: Some accesses are ignored on write and return zero on read: an enable pattern that is neither a lone task file lane nor a data port size, an all-zero pattern, and an address outside every channel.
- R9: A first-dword write with enables 4'b0001, 4'b0011 or 4'b1111 raises `dout_valid` with `bus_wdata`, `bus_be` and the channel on `dp_chan`. `bus_stall` is high while `dout_ready` is low.
- R10: A first-dword read with those data port patterns raises `din_ready` and stalls while `din_valid` is low. Once the pop completes, `din_data` is returned with every non-enabled lane forced to zero.
- R11: `rd_valid` is high in exactly the cycle after each accepted read and at no other time.
- R12: `bus_stall` is high only for a data port access whose device-side handshake is not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, held until not stalled |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_dw_addr | input | DWA_W | Dword address (byte address / 4) |
| bus_be | input | 4 | Byte enables, bit i = lane bits 8i+7:8i |
| bus_wdata | input | 32 | Write data |
| bus_stall | output | 1 | Request not accepted this cycle |
| rd_valid | output | 1 | Read data valid, one cycle after acceptance |
| rd_data | output | 32 | Read data |
| dev_err | input | NUM_CH*8 | Error byte per channel, channel c in bits 8c+7:8c |
| dev_stat | input | NUM_CH*8 | Status byte per channel |
| cmd_strobe | output | NUM_CH | One-cycle command pulse per channel |
| cmd_code | output | 8 | Command byte of the last pulse |
| cmd_feat | output | 8 | Features value sent with the pulse |
| dout_valid | output | 1 | Data port write word valid |
| dout_ready | input | 1 | Device accepts write word |
| dout_data | output | 32 | Data port write word |
| dout_be | output | 4 | Lanes carried by the write word |
| din_valid | input | 1 | Device read word valid |
| din_ready | output | 1 | Data port read pops the word |
| din_data | input | 32 | Device read word |
| dp_chan | output | CH_W | Channel of the current data port access |

## Verification
The decode is exercised with every lone byte enable on both dwords of all four channels. It is also exercised with the three data port sizes and with wide or split patterns on dwords where they are not legal. Together these separate a decode that keys on the address alone from one that also weighs the access size. The split-personality lanes are written with values that differ from the live device inputs, and a device input is changed after a write. A stored value would then show up on read-back. Device/head is written with bit 4 set on every channel, which separates channels that keep that bit from those that drop it. Data port transfers are run with the device side ready at once and after a delay, so the stall and the masking of non-enabled lanes are both observed.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  typedef enum logic [3:0] {
    TF_NONE,
    TF_DATA,
    TF_SECNUM,
    TF_SECCNT,
    TF_FEAT_ERR,
    TF_CYL_LO,
    TF_CYL_HI,
    TF_DEVHEAD,
    TF_CMD_STAT
  } tf_lane_e;

  // dword address of channel c's first task file dword
  function automatic int chan_base_dw(int c);
    return 'h20 + 'h10 * (c % 2) + 'h80 * (c / 2);
  endfunction

  // first dword: lone lanes are registers, lane-0-anchored sizes are data
  function automatic tf_lane_e lane_word0(logic [3:0] be);
    case (be)
      4'b0001, 4'b0011, 4'b1111: return TF_DATA;
      4'b1000:                   return TF_SECNUM;
      4'b0100:                   return TF_SECCNT;
      4'b0010:                   return TF_FEAT_ERR;
      default:                   return TF_NONE;
    endcase
  endfunction

  // second dword: lone lanes only
  function automatic tf_lane_e lane_word1(logic [3:0] be);
    case (be)
      4'b1000: return TF_CMD_STAT;
      4'b0100: return TF_DEVHEAD;
      4'b0010: return TF_CYL_HI;
      4'b0001: return TF_CYL_LO;
      default: return TF_NONE;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DWA_W  = 8,
  parameter int CH_W   = 2
) (
  input  logic [DWA_W-1:0] dw_addr,
  input  logic [3:0]       be,
  output logic             hit,
  output logic [CH_W-1:0]  chan,
  output tf_lane_e         lane
);

  logic [NUM_CH-1:0] match_w0;
  logic [NUM_CH-1:0] match_w1;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_match
      assign match_w0[c] = (int'(dw_addr) == chan_base_dw(c));
      assign match_w1[c] = (int'(dw_addr) == chan_base_dw(c) + 1);
    end
  endgenerate

  always_comb begin
    chan = '0;
    lane = TF_NONE;
    for (int c = 0; c < NUM_CH; c++) begin
      if (match_w0[c]) begin
        chan = CH_W'(c);
        lane = lane_word0(be);
      end else if (match_w1[c]) begin
        chan = CH_W'(c);
        lane = lane_word1(be);
      end
    end
    hit = (lane != TF_NONE);
  end

endmodule

// File: rtl/ata_tf_chan_regs.sv
module ata_tf_chan_regs
  import ata_tf_pkg::*;
#(
  parameter bit HONOR_DEVSEL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  tf_lane_e    lane,
  input  logic [31:0] wdata,
  output logic [7:0]  secnum,
  output logic [7:0]  seccnt,
  output logic [7:0]  feat,
  output logic [7:0]  cyl_lo,
  output logic [7:0]  cyl_hi,
  output logic [7:0]  devhead
);

  logic [7:0] devhead_in;

  generate
    if (HONOR_DEVSEL) begin : g_devsel_kept
      assign devhead_in = wdata[23:16];
    end else begin : g_devsel_dropped
      assign devhead_in = {wdata[23:21], 1'b0, wdata[19:16]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secnum  <= '0;
      seccnt  <= '0;
      feat    <= '0;
      cyl_lo  <= '0;
      cyl_hi  <= '0;
      devhead <= '0;
    end else if (wr_en) begin
      case (lane)
        TF_SECNUM:   secnum  <= wdata[31:24];
        TF_SECCNT:   seccnt  <= wdata[23:16];
        TF_FEAT_ERR: feat    <= wdata[15:8];
        TF_CYL_LO:   cyl_lo  <= wdata[7:0];
        TF_CYL_HI:   cyl_hi  <= wdata[15:8];
        TF_DEVHEAD:  devhead <= devhead_in;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ata_tf_dataport.sv
module ata_tf_dataport
  import ata_tf_pkg::*;
(
  input  logic        req,
  input  logic        we,
  input  logic        is_data,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        dout_ready,
  input  logic        din_valid,
  input  logic [31:0] din_data,
  output logic        stall,
  output logic        dout_valid,
  output logic [31:0] dout_data,
  output logic [3:0]  dout_be,
  output logic        din_ready,
  output logic [31:0] rd_word
);

  assign dout_valid = req & we & is_data;
  assign din_ready  = req & ~we & is_data;
  assign dout_data  = wdata;
  assign dout_be    = be;
  assign stall      = (dout_valid & ~dout_ready) | (din_ready & ~din_valid);
  assign rd_word    = din_data & lane_mask(be);

endmodule

// File: rtl/ata_tf_window.sv
module ata_tf_window
  import ata_tf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DWA_W  = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [DWA_W-1:0]      bus_dw_addr,
  input  logic [3:0]            bus_be,
  input  logic [31:0]           bus_wdata,
  output logic                  bus_stall,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  input  logic [NUM_CH*8-1:0]   dev_err,
  input  logic [NUM_CH*8-1:0]   dev_stat,
  output logic [NUM_CH-1:0]     cmd_strobe,
  output logic [7:0]            cmd_code,
  output logic [7:0]            cmd_feat,
  output logic                  dout_valid,
  input  logic                  dout_ready,
  output logic [31:0]           dout_data,
  output logic [3:0]            dout_be,
  input  logic                  din_valid,
  output logic                  din_ready,
  input  logic [31:0]           din_data,
  output logic [CH_W-1:0]       dp_chan
);

  logic            dec_hit;
  logic [CH_W-1:0] dec_chan;
  tf_lane_e        dec_lane;
  logic            accept;
  logic            is_data;
  logic [31:0]     rd_word;
  logic [31:0]     rd_next;

  logic [7:0] r_secnum [NUM_CH];
  logic [7:0] r_seccnt [NUM_CH];
  logic [7:0] r_feat   [NUM_CH];
  logic [7:0] r_cyl_lo [NUM_CH];
  logic [7:0] r_cyl_hi [NUM_CH];
  logic [7:0] r_devhd  [NUM_CH];

  ata_tf_decode #(
    .NUM_CH (NUM_CH),
    .DWA_W  (DWA_W),
    .CH_W   (CH_W)
  ) u_decode (
    .dw_addr (bus_dw_addr),
    .be      (bus_be),
    .hit     (dec_hit),
    .chan    (dec_chan),
    .lane    (dec_lane)
  );

  assign is_data = (dec_lane == TF_DATA);
  assign dp_chan = dec_chan;

  ata_tf_dataport u_dataport (
    .req        (bus_req),
    .we         (bus_we),
    .is_data    (is_data),
    .be         (bus_be),
    .wdata      (bus_wdata),
    .dout_ready (dout_ready),
    .din_valid  (din_valid),
    .din_data   (din_data),
    .stall      (bus_stall),
    .dout_valid (dout_valid),
    .dout_data  (dout_data),
    .dout_be    (dout_be),
    .din_ready  (din_ready),
    .rd_word    (rd_word)
  );

  assign accept = bus_req & ~bus_stall;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic wr_en;
      assign wr_en = accept & bus_we & dec_hit & ~is_data & (int'(dec_chan) == c);
      ata_tf_chan_regs #(
        .HONOR_DEVSEL (c < 2)
      ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .lane    (dec_lane),
        .wdata   (bus_wdata),
        .secnum  (r_secnum[c]),
        .seccnt  (r_seccnt[c]),
        .feat    (r_feat[c]),
        .cyl_lo  (r_cyl_lo[c]),
        .cyl_hi  (r_cyl_hi[c]),
        .devhead (r_devhd[c])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    case (dec_lane)
      TF_DATA:     rd_next = rd_word;
      TF_SECNUM:   rd_next = {r_secnum[dec_chan], 24'h0};
      TF_SECCNT:   rd_next = {8'h0, r_seccnt[dec_chan], 16'h0};
      TF_FEAT_ERR: rd_next = {16'h0, dev_err[int'(dec_chan)*8 +: 8], 8'h0};
      TF_CYL_LO:   rd_next = {24'h0, r_cyl_lo[dec_chan]};
      TF_CYL_HI:   rd_next = {16'h0, r_cyl_hi[dec_chan], 8'h0};
      TF_DEVHEAD:  rd_next = {8'h0, r_devhd[dec_chan], 16'h0};
      TF_CMD_STAT: rd_next = {dev_stat[int'(dec_chan)*8 +: 8], 24'h0};
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept & ~bus_we;
      if (accept & ~bus_we) rd_data <= rd_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_strobe <= '0;
      cmd_code   <= '0;
      cmd_feat   <= '0;
    end else begin
      cmd_strobe <= '0;
      if (accept & bus_we & (dec_lane == TF_CMD_STAT)) begin
        cmd_strobe[dec_chan] <= 1'b1;
        cmd_code             <= bus_wdata[31:24];
        cmd_feat             <= r_feat[dec_chan];
      end
    end
  end

endmodule

// File: rtl/ata_tf_window_chk.sv
module ata_tf_window_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_stall,
  input logic              rd_valid,
  input logic [NUM_CH-1:0] cmd_strobe,
  input logic              dout_valid,
  input logic              dout_ready,
  input logic              din_valid,
  input logic              din_ready
);

  assert_rd_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_req && !bus_we && !bus_stall));

  assert_accept_gives_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && !bus_stall) |=> rd_valid);

  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  assert_strobe_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_strobe) |-> $past(bus_req && bus_we && !bus_stall));

  assert_stall_only_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall |-> (dout_valid || din_ready));

  assert_push_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |-> bus_stall);

  assert_pop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (din_ready && din_valid) |-> !bus_stall);

endmodule

bind ata_tf_window ata_tf_window_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/ata_tf_window_test.sv
module ata_tf_window_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_req = 1'b0;
  logic        b_we = 1'b0;
  logic [9:0]  b_addr = '0;
  logic [3:0]  b_be = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_err = 32'hE3E2E1E0;
  logic [31:0] b_stat = 32'h53525150;
  logic        dout_ready = 1'b1;
  logic        din_valid = 1'b0;
  logic [31:0] din_data = '0;

  logic        bus_stall, rd_valid, dout_valid, din_ready;
  logic [31:0] rd_data, dout_data;
  logic [3:0]  cmd_strobe, dout_be;
  logic [7:0]  cmd_code, cmd_feat;
  logic [1:0]  dp_chan;

  always #4 clk = ~clk;  // 125 MHz

  ata_tf_window uut (
    .clk (clk), .rst_n (rst_n),
    .bus_req (b_req), .bus_we (b_we), .bus_dw_addr (b_addr[9:2]),
    .bus_be (b_be), .bus_wdata (b_wdata), .bus_stall (bus_stall),
    .rd_valid (rd_valid), .rd_data (rd_data),
    .dev_err (b_err), .dev_stat (b_stat),
    .cmd_strobe (cmd_strobe), .cmd_code (cmd_code), .cmd_feat (cmd_feat),
    .dout_valid (dout_valid), .dout_ready (dout_ready),
    .dout_data (dout_data), .dout_be (dout_be),
    .din_valid (din_valid), .din_ready (din_ready), .din_data (din_data),
    .dp_chan (dp_chan)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference decode: returns kind + 16*channel
  // kinds: 0 none, 1 data, 2 secnum, 3 seccnt, 4 feat/err, 5 cyl lo, 6 cyl hi, 7 dev/head, 8 cmd/stat
  function automatic int ref_decode(logic [9:0] a, logic [3:0] be);
    int bases [4] = '{'h80, 'hC0, 'h280, 'h2C0};
    for (int c = 0; c < 4; c++) begin
      if ({a[9:2], 2'b00} == 10'(bases[c])) begin
        if (be == 4'h1 || be == 4'h3 || be == 4'hF) return 1 + 16*c;
        if (be == 4'h8) return 2 + 16*c;
        if (be == 4'h4) return 3 + 16*c;
        if (be == 4'h2) return 4 + 16*c;
        return 0;
      end
      if ({a[9:2], 2'b00} == 10'(bases[c] + 4)) begin
        if (be == 4'h8) return 8 + 16*c;
        if (be == 4'h4) return 7 + 16*c;
        if (be == 4'h2) return 6 + 16*c;
        if (be == 4'h1) return 5 + 16*c;
        return 0;
      end
    end
    return 0;
  endfunction

  function automatic logic [31:0] be_mask(logic [3:0] be);
    logic [31:0] m = '0;
    if (be[0]) m = m | 32'h0000_00FF;
    if (be[1]) m = m | 32'h0000_FF00;
    if (be[2]) m = m | 32'h00FF_0000;
    if (be[3]) m = m | 32'hFF00_0000;
    return m;
  endfunction

  // reference state
  logic [7:0] m_sn [4], m_sc [4], m_ft [4], m_cl [4], m_ch [4], m_dh [4];
  logic        e_rdv;
  logic [31:0] e_rdd;
  string       e_tag;
  logic [3:0]  e_strobe;
  logic [7:0]  e_code, e_feat;

  logic m_stall;
  logic m_isdata;
  always_comb begin
    m_isdata = b_req && ((ref_decode(b_addr, b_be) % 16) == 1);
    m_stall  = m_isdata && (b_we ? !dout_ready : !din_valid);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_sn[c] = 0; m_sc[c] = 0; m_ft[c] = 0; m_cl[c] = 0; m_ch[c] = 0; m_dh[c] = 0;
      end
      e_rdv = 0; e_rdd = 0; e_strobe = 0; e_code = 0; e_feat = 0; e_tag = "R1";
    end else begin
      int d, k, ch;
      d  = ref_decode(b_addr, b_be);
      k  = d % 16;
      ch = d / 16;
      e_rdv    = 0;
      e_strobe = 0;
      if (b_req && !m_stall) begin
        if (b_we) begin
          case (k)
            2: m_sn[ch] = b_wdata[31:24];
            3: m_sc[ch] = b_wdata[23:16];
            4: m_ft[ch] = b_wdata[15:8];
            5: m_cl[ch] = b_wdata[7:0];
            6: m_ch[ch] = b_wdata[15:8];
            7: m_dh[ch] = (ch >= 2) ? (b_wdata[23:16] & 8'hEF) : b_wdata[23:16];
            8: begin e_strobe[ch] = 1'b1; e_code = b_wdata[31:24]; e_feat = m_ft[ch]; end
            default: ;
          endcase
        end else begin
          e_rdv = 1;
          case (k)
            1: begin e_rdd = din_data & be_mask(b_be);       e_tag = "R10"; end
            2: begin e_rdd = {m_sn[ch], 24'h0};               e_tag = "R2/R3"; end
            3: begin e_rdd = {8'h0, m_sc[ch], 16'h0};         e_tag = "R2/R3"; end
            4: begin e_rdd = {16'h0, b_err[ch*8 +: 8], 8'h0}; e_tag = "R5"; end
            5: begin e_rdd = {24'h0, m_cl[ch]};               e_tag = "R2/R4"; end
            6: begin e_rdd = {16'h0, m_ch[ch], 8'h0};         e_tag = "R2/R4"; end
            7: begin e_rdd = {8'h0, m_dh[ch], 16'h0};         e_tag = (ch >= 2) ? "R7" : "R4"; end
            8: begin e_rdd = {b_stat[ch*8 +: 8], 24'h0};      e_tag = "R5"; end
            default: begin e_rdd = 0;                         e_tag = "R8"; end
          endcase
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "rd_valid in reset", {31'h0, rd_valid}, 0);
      chk("R1", "cmd_strobe in reset", {28'h0, cmd_strobe}, 0);
    end else begin
      chk("R11", "rd_valid", {31'h0, rd_valid}, {31'h0, e_rdv});
      if (e_rdv) chk(e_tag, "rd_data", rd_data, e_rdd);
      chk("R6", "cmd_strobe", {28'h0, cmd_strobe}, {28'h0, e_strobe});
      if (e_strobe != 0) begin
        chk("R6", "cmd_code", {24'h0, cmd_code}, {24'h0, e_code});
        chk("R6", "cmd_feat", {24'h0, cmd_feat}, {24'h0, e_feat});
      end
      chk(m_isdata ? (b_we ? "R9" : "R10") : "R12", "bus_stall",
          {31'h0, bus_stall}, {31'h0, m_stall});
      chk("R9", "dout_valid", {31'h0, dout_valid}, {31'h0, m_isdata && b_we});
      chk("R10", "din_ready", {31'h0, din_ready}, {31'h0, m_isdata && !b_we});
      if (m_isdata && b_we) begin
        chk("R9", "dout_data", dout_data, b_wdata);
        chk("R9", "dout_be", {28'h0, dout_be}, {28'h0, b_be});
      end
      if (m_isdata)
        chk("R9", "dp_chan", {30'h0, dp_chan}, 32'(ref_decode(b_addr, b_be) / 16));
    end
  end

  // caller is at posedge+2; returns at posedge+2 after the accepting edge
  task automatic access(logic we, logic [9:0] a, logic [3:0] be, logic [31:0] wd);
    logic acc;
    b_req = 1; b_we = we; b_addr = a; b_be = be; b_wdata = wd;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      acc = !bus_stall;
      @(posedge clk);
      #2;
    end
    b_req = 0;
  endtask

  function automatic logic [9:0] base_of(int c);
    return 10'('h80 + 'h40 * (c % 2) + 'h200 * (c / 2));
  endfunction

  task automatic read_all(int c);
    access(0, base_of(c),     4'h8, 0);
    access(0, base_of(c),     4'h4, 0);
    access(0, base_of(c),     4'h2, 0);
    access(0, base_of(c) + 4, 4'h8, 0);
    access(0, base_of(c) + 4, 4'h4, 0);
    access(0, base_of(c) + 4, 4'h2, 0);
    access(0, base_of(c) + 4, 4'h1, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;

    // R1: everything reads zero after reset; R2: every channel base
    for (int c = 0; c < 4; c++) read_all(c);

    // R3 R4 R7: load each channel, dev/head with bit 4 set
    for (int c = 0; c < 4; c++) begin
      access(1, base_of(c),     4'h8, {8'h10 + 8'(c), 24'h0});
      access(1, base_of(c),     4'h4, {8'h0, 8'h20 + 8'(c), 16'h0});
      access(1, base_of(c),     4'h2, {16'h0, 8'h30 + 8'(c), 8'h0});
      access(1, base_of(c) + 4, 4'h1, {24'h0, 8'h40 + 8'(c)});
      access(1, base_of(c) + 4, 4'h2, {16'h0, 8'h60 + 8'(c), 8'h0});
      access(1, base_of(c) + 4, 4'h4, {8'h0, 8'hF0 + 8'(c), 16'h0});
      // R6: command strobe with features
      access(1, base_of(c) + 4, 4'h8, {8'hC8 + 8'(c), 24'h0});
      read_all(c);
    end

    // R5: error / status follow the device inputs
    b_err  = 32'h0BADF00D;
    b_stat = 32'hA1B2C3D4;
    access(0, base_of(0),     4'h2, 0);
    access(0, base_of(3) + 4, 4'h8, 0);
    access(1, base_of(1),     4'h2, 32'hFFFF_FFFF);
    access(0, base_of(1),     4'h2, 0);

    // R8: illegal patterns and unmapped address ignored / read zero
    access(1, base_of(0) + 4, 4'hF, 32'hFFFF_FFFF);
    access(1, base_of(0) + 4, 4'h3, 32'hFFFF_FFFF);
    access(1, base_of(0),     4'h5, 32'hFFFF_FFFF);
    access(1, base_of(0),     4'h0, 32'hFFFF_FFFF);
    access(1, 10'h100,        4'h8, 32'hFFFF_FFFF);
    access(0, base_of(0) + 4, 4'hF, 0);
    access(0, base_of(0),     4'h6, 0);
    access(0, 10'h100,        4'h8, 0);
    read_all(0);

    // R9: data writes, first one back-pressured
    dout_ready = 0;
    fork
      access(1, base_of(2), 4'hF, 32'hA5A5_5A5A);
      begin repeat (3) @(posedge clk); #1 dout_ready = 1; end
    join
    access(1, base_of(1), 4'h1, 32'h1234_5678);
    access(1, base_of(3), 4'h3, 32'h9ABC_DEF0);

    // R10: data reads, first one waits for the device
    din_data = 32'hCAFE_BEEF;
    fork
      access(0, base_of(0), 4'hF, 0);
      begin repeat (4) @(posedge clk); #1 din_valid = 1; end
    join
    access(0, base_of(2), 4'h1, 0);
    din_data = 32'h7654_3210;
    access(0, base_of(3), 4'h3, 0);
    din_valid = 0;

    // R6: command again after a features change
    access(1, base_of(2),     4'h2, {16'h0, 8'h99, 8'h0});
    access(1, base_of(2) + 4, 4'h8, {8'hEC, 24'h0});

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule